// File: doc/BRIEF.md
# Parity Error Capture Unit

This block sits between a requester and a 32-bit memory array and protects each stored byte with one parity bit. On every write it computes an odd-parity bit for each byte lane and sends it to the array beside the data. On every read it checks the returned data against the returned parity bits. If checking is switched on and any lane is wrong, it records the read address and a per-lane failure map, sets a sticky error flag, and raises an interrupt request whose enable is a separate control bit.

To let software exercise the error path, a diagnostic force mode stores wrong parity on purpose, on the byte lanes chosen by a lane mask. The next read of that word then reports an error. A small register port gives access to three registers: control, captured error address and captured lane status. The first error is held until software writes zero to the error-address register. That write clears the flag, the captured values and the interrupt.

The array returns read data and parity exactly one cycle after the read request.

Top module: `par_err_unit`

## Requirements
- R1: After reset the control register reads 0, the error-address and error-status registers read 0, and `irq` is 0.
- R2: With force mode off, a write drives `arr_wpar[i]` so that byte lane i (`arr_wdata[8i+7:8i]`) and its parity bit together hold an odd number of ones.
- R3: With force mode on, `arr_wpar[i]` is the inverse of the R2 value for every lane i whose mask bit (control bit 4+i) is 1, and equals the R2 value on the other lanes.
- R4: With checking on, a read whose data and parity are consistent leaves `irq` at 0, leaves the error-status register at 0, and leaves the control register reading back what was written.
- R5: With checking on and no error held, a read with one or more bad lanes sets the flag (control bit 3). At the clock edge that ends the data-return cycle it also loads the read address into the error-address register (select 1) and loads the bad-lane map (bit i = lane i) into the error-status register (select 2).
- R6: With checking off (control bit 0 = 0), a read with bad parity has no effect on the flag, the error address or the error status.
- R7: `irq` is 1 exactly when the interrupt-enable bit (control bit 2) and the error flag are both 1. Setting the enable while an error is held raises `irq` without any further read.
- R8: While an error is held, later bad reads do not change the error address or the error status.
- R9: Writing zero to the error-address register clears the flag, the error address, the error status and `irq`. A nonzero write to that register has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Memory access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access word address |
| acc_wdata | input | DATA_W | Write data |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_wpar | output | DATA_W/8 | Array write parity, one bit per byte lane |
| arr_rdata | input | DATA_W | Array read data, valid one cycle after `arr_re` |
| arr_rpar | input | DATA_W/8 | Array read parity, valid with `arr_rdata` |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 error address, 2 error status, 3 reads zero |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Selected register contents |
| irq | output | 1 | Level-7 error interrupt request |

## Verification
A flag that is wrongly held or wrongly dropped shows on `irq` and on control bit 3 at the first clock edge after the data-return cycle. It also shows one edge after a clearing write. A wrong capture path loads an address or lane map that differs from the stimulus, and this can be read back as soon as the capture edge has passed. A lost hold lets a second forced error overwrite the first, so a read after the second error shows the wrong address. A wrong parity generator shows on `arr_wpar` in the same cycle as the write, and the lane that differs points to the faulty lane or mask bit.

// File: rtl/perr_pkg.sv
package perr_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_EADDR = 2'd1,
        SEL_ESTAT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int CTL_CHECK    = 0;
    localparam int CTL_FORCE    = 1;
    localparam int CTL_IRQEN    = 2;
    localparam int CTL_FLAG     = 3;
    localparam int CTL_MASK_LSB = 4;

    typedef struct packed {
        logic check_en;
        logic force_en;
        logic irq_en;
    } ctl_bits_t;

    // parity bit that makes the lane plus the bit hold an odd count of ones
    function automatic logic odd_par(input logic [LANE_W-1:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/perr_gen.sv
module perr_gen
    import perr_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] wdata,
    input  logic              force_en,
    input  logic [LANES-1:0]  force_mask,
    output logic [LANES-1:0]  wpar
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic flip;
        assign flip    = force_en & force_mask[g];
        assign wpar[g] = odd_par(wdata[g*LANE_W +: LANE_W]) ^ flip;
    end
endmodule

// File: rtl/perr_chk.sv
module perr_chk
    import perr_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [LANES-1:0]  rpar,
    output logic [LANES-1:0]  lane_bad
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bad[g] = ~(^{rdata[g*LANE_W +: LANE_W], rpar[g]});
    end
endmodule

// File: rtl/perr_regs.sv
module perr_regs
    import perr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hit,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic [LANES-1:0]  hit_lanes,
    output ctl_bits_t         ctl,
    output logic [LANES-1:0]  force_mask,
    output logic              flag,
    output logic [ADDR_W-1:0] err_addr,
    output logic [LANES-1:0]  err_lanes
);
    logic clear;
    logic capture;

    assign clear   = reg_wr && (sel == SEL_EADDR) && (reg_wdata == '0);
    assign capture = hit && ctl.check_en && !flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl        <= '0;
            force_mask <= '0;
        end else if (reg_wr && sel == SEL_CTRL) begin
            ctl.check_en <= reg_wdata[CTL_CHECK];
            ctl.force_en <= reg_wdata[CTL_FORCE];
            ctl.irq_en   <= reg_wdata[CTL_IRQEN];
            force_mask   <= reg_wdata[CTL_MASK_LSB +: LANES];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            flag      <= 1'b0;
            err_addr  <= '0;
            err_lanes <= '0;
        end else if (capture) begin
            flag      <= 1'b1;
            err_addr  <= hit_addr;
            err_lanes <= hit_lanes;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                reg_rdata[CTL_CHECK]               = ctl.check_en;
                reg_rdata[CTL_FORCE]               = ctl.force_en;
                reg_rdata[CTL_IRQEN]               = ctl.irq_en;
                reg_rdata[CTL_FLAG]                = flag;
                reg_rdata[CTL_MASK_LSB +: LANES]   = force_mask;
            end
            SEL_EADDR: reg_rdata[ADDR_W-1:0] = err_addr;
            SEL_ESTAT: reg_rdata[LANES-1:0]  = err_lanes;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/par_err_unit.sv
module par_err_unit
    import perr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              arr_we,
    output logic              arr_re,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [LANES-1:0]  arr_wpar,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [LANES-1:0]  arr_rpar,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    ctl_bits_t         ctl;
    logic [LANES-1:0]  force_mask;
    logic              flag;
    logic [ADDR_W-1:0] err_addr;
    logic [LANES-1:0]  err_lanes;
    logic [LANES-1:0]  lane_bad;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr;
    logic              hit;
    reg_sel_e          sel;

    assign sel       = reg_sel_e'(reg_sel);
    assign arr_we    = acc_req && acc_we;
    assign arr_re    = acc_req && !acc_we;
    assign arr_addr  = acc_addr;
    assign arr_wdata = acc_wdata;

    // read return arrives one cycle after the request: remember its address
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_pend <= arr_re;
            if (arr_re) rd_addr <= acc_addr;
        end
    end

    perr_gen #(.DATA_W(DATA_W)) u_gen (
        .wdata      (acc_wdata),
        .force_en   (ctl.force_en),
        .force_mask (force_mask),
        .wpar       (arr_wpar)
    );

    perr_chk #(.DATA_W(DATA_W)) u_chk (
        .rdata    (arr_rdata),
        .rpar     (arr_rpar),
        .lane_bad (lane_bad)
    );

    assign hit = rd_pend && (|lane_bad);

    perr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .sel        (sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .hit        (hit),
        .hit_addr   (rd_addr),
        .hit_lanes  (lane_bad),
        .ctl        (ctl),
        .force_mask (force_mask),
        .flag       (flag),
        .err_addr   (err_addr),
        .err_lanes  (err_lanes)
    );

    assign irq = ctl.irq_en && flag;
endmodule

// File: rtl/par_err_unit_chk.sv
module par_err_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              arr_we,
    input logic [DATA_W-1:0] arr_wdata,
    input logic [LANES-1:0]  arr_wpar,
    input logic              force_en,
    input logic              check_en,
    input logic              irq_en,
    input logic              flag,
    input logic              irq,
    input logic [ADDR_W-1:0] err_addr,
    input logic [LANES-1:0]  err_lanes,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata
);
    logic clr_wr;
    assign clr_wr = reg_wr && reg_sel == 2'd1 && reg_wdata == '0;

    for (genvar g = 0; g < LANES; g++) begin : g_odd
        // R2: normal writes keep every lane odd
        p_odd_lane_r2: assert property (@(posedge clk) disable iff (rst)
            (arr_we && !force_en) |-> (^{arr_wdata[g*8 +: 8], arr_wpar[g]}));
    end

    p_flag_has_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (err_lanes != '0));

    p_nocheck_r6: assert property (@(posedge clk) disable iff (rst)
        (!check_en && !flag && !clr_wr) |=> !flag);

    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && flag));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_wr) |=> ($stable(err_addr) && $stable(err_lanes) && flag));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> (!flag && err_addr == '0 && err_lanes == '0 && !irq));
endmodule

bind par_err_unit par_err_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bind_chk (
    .clk       (clk),
    .rst       (rst),
    .arr_we    (arr_we),
    .arr_wdata (arr_wdata),
    .arr_wpar  (arr_wpar),
    .force_en  (ctl.force_en),
    .check_en  (ctl.check_en),
    .irq_en    (ctl.irq_en),
    .flag      (flag),
    .irq       (irq),
    .err_addr  (err_addr),
    .err_lanes (err_lanes),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata)
);

// File: tb/sim_par_err_unit.sv
`timescale 1ns/1ps
module sim_par_err_unit;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int LN = DW / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_req = 1'b0, acc_we = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic          arr_we, arr_re;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;
    logic [LN-1:0] arr_wpar;
    logic [DW-1:0] arr_rdata;
    logic [LN-1:0] arr_rpar;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    par_err_unit #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk, .rst, .acc_req, .acc_we, .acc_addr, .acc_wdata,
        .arr_we, .arr_re, .arr_addr, .arr_wdata, .arr_wpar,
        .arr_rdata, .arr_rpar, .reg_wr, .reg_sel, .reg_wdata,
        .reg_rdata, .irq
    );

    // memory array model, one-cycle read latency
    logic [DW-1:0] mem_d [0:255];
    logic [LN-1:0] mem_p [0:255];
    logic [DW-1:0] rd_q = '0;
    logic [LN-1:0] rp_q = '0;
    always @(posedge clk) begin
        if (arr_we) begin
            mem_d[arr_addr[7:0]] <= arr_wdata;
            mem_p[arr_addr[7:0]] <= arr_wpar;
        end
        if (arr_re) begin
            rd_q <= mem_d[arr_addr[7:0]];
            rp_q <= mem_p[arr_addr[7:0]];
        end
    end
    assign arr_rdata = rd_q;
    assign arr_rpar  = rp_q;

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // scoreboard of expected irq after each read
    typedef struct { int due; logic exp_irq; string req; } sb_t;
    sb_t sbq[$];

    always @(posedge clk) begin
        #2;
        cyc++;
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            sb_t it;
            it = sbq.pop_front();
            check(it.req, {31'b0, irq}, {31'b0, it.exp_irq});
        end
    end

    task automatic mem_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic [LN-1:0] par);
        @(negedge clk);
        acc_req = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
        #1 par = arr_wpar;
        @(negedge clk);
        acc_req = 0; acc_we = 0;
    endtask

    task automatic mem_read(input logic [AW-1:0] a, input logic exp_irq, input string req);
        sb_t it;
        @(negedge clk);
        acc_req = 1; acc_we = 0; acc_addr = a;
        it.due = cyc + 2; it.exp_irq = exp_irq; it.req = req;
        sbq.push_back(it);
        @(negedge clk);
        acc_req = 0;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [DW-1:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [LN-1:0] p;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        reg_read(2'd0, v); check("R1 ctrl", v, 0);
        reg_read(2'd1, v); check("R1 eaddr", v, 0);
        reg_read(2'd2, v); check("R1 estat", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 normal parity: lanes 01,03,FF,00 -> 0,1,1,1
        mem_write(16'h0040, 32'h00FF_0301, p);
        check("R2 wpar", {28'b0, p}, 32'hE);
        mem_write(16'h0041, 32'h8001_7F10, p);   // 10:0 7F:0 01:0 80:0
        check("R2 wpar b", {28'b0, p}, 32'h0);

        // R3 force lanes 0 and 2
        reg_write(2'd0, 32'h0000_0052);
        mem_write(16'h0042, 32'h00FF_0301, p);
        check("R3 wpar forced", {28'b0, p}, 32'hB);

        // R4 good round trip, check + irq enable
        reg_write(2'd0, 32'h0000_0005);
        mem_write(16'h0010, 32'hA5A5_1234, p);
        mem_read(16'h0010, 1'b0, "R4 irq");
        reg_read(2'd0, v); check("R4 ctrl", v, 32'h5);
        reg_read(2'd2, v); check("R4 estat", v, 0);

        // R5 forced error on lanes 1,2 then read
        reg_write(2'd0, 32'h0000_0067);
        mem_write(16'h0022, 32'h1357_9BDF, p);
        reg_write(2'd0, 32'h0000_0005);
        mem_read(16'h0022, 1'b1, "R5 irq");
        reg_read(2'd1, v); check("R5 eaddr", v, 32'h22);
        reg_read(2'd2, v); check("R5 estat", v, 32'h6);
        reg_read(2'd0, v); check("R5 ctrl flag", v, 32'hD);

        // R8 second error on lane 3 must not overwrite
        reg_write(2'd0, 32'h0000_0087);
        mem_write(16'h0033, 32'h0000_0000, p);
        reg_write(2'd0, 32'h0000_0005);
        mem_read(16'h0033, 1'b1, "R8 irq");
        reg_read(2'd1, v); check("R8 eaddr held", v, 32'h22);
        reg_read(2'd2, v); check("R8 estat held", v, 32'h6);

        // R9 nonzero write ignored, zero write clears
        reg_write(2'd1, 32'h0000_0001);
        reg_read(2'd1, v); check("R9 nonzero ignored", v, 32'h22);
        check("R9 irq kept", {31'b0, irq}, 1);
        reg_write(2'd1, 32'h0);
        reg_read(2'd1, v); check("R9 eaddr clr", v, 0);
        reg_read(2'd2, v); check("R9 estat clr", v, 0);
        reg_read(2'd0, v); check("R9 ctrl", v, 32'h5);
        check("R9 irq clr", {31'b0, irq}, 0);

        // R6 checking off: bad read ignored
        reg_write(2'd0, 32'h0000_0004);
        mem_read(16'h0033, 1'b0, "R6 irq");
        reg_read(2'd2, v); check("R6 estat", v, 0);
        reg_read(2'd1, v); check("R6 eaddr", v, 0);
        reg_read(2'd0, v); check("R6 ctrl", v, 32'h4);

        // R7 irq masked, flag still captures, enable raises irq
        reg_write(2'd0, 32'h0000_0001);
        mem_read(16'h0033, 1'b0, "R7 irq masked");
        reg_read(2'd2, v); check("R7 estat", v, 32'h8);
        reg_read(2'd1, v); check("R7 eaddr", v, 32'h33);
        reg_read(2'd0, v); check("R7 ctrl flag", v, 32'h9);
        reg_write(2'd0, 32'h0000_0005);
        #1 check("R7 irq on enable", {31'b0, irq}, 1);

        repeat (4) @(negedge clk);
        check("scoreboard drained", sbq.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule